// File: doc/BRIEF.md
# Bidirectional Mailbox Register Bank

This block passes short messages between an external serial host and a local microcontroller through two sets of mailbox registers that point in opposite directions. The inbound set can only be written by the host and read by the microcontroller. The outbound set works the other way: the microcontroller writes it and the host reads it. Each inbound mailbox has a sticky pending flag, so the microcontroller can tell which mailboxes hold new messages. A single enable bit gates those flags onto one interrupt line.

Host accesses come from the serial clock domain. They are modelled as a four-phase request/acknowledge handshake. The host places its direction, index and data on the port and holds them, then raises a request. The bank passes the request through a two-flop synchronizer and then an edge detector. The access takes effect exactly once for each rising edge of the request. The acknowledge follows the synchronized request. The microcontroller uses a plain register port: a select, a write enable, an address, and write data, with read data returned combinationally.

Top module: `mbx_bank`

## Requirements
- R1: After reset, every mailbox reads 0, the pending flags (address 8, bits 3:0) read 0, the enable (address 9, bit 0) reads 0, and `irq` and `hst_ack` are 0.
- R2: A host request with `hst_dir`=1 stores `hst_wdata` into inbound mailbox `hst_idx`. `hst_ack` rises on the third rising clock edge after `hst_req` rises. From that edge onward, the stored value reads back at microcontroller address `hst_idx` (0..3).
- R3: A host request with `hst_dir`=0 returns outbound mailbox `hst_idx` on `hst_rdata` from the edge where `hst_ack` rises. That value is held until the next host read.
- R4: A microcontroller write to address 4+k (k = 0..3) replaces outbound mailbox k, and the new value reads back at the same address.
- R5: Microcontroller writes to addresses 0..3 have no effect on the inbound mailboxes.
- R6: A host write sets pending flag `hst_idx` (address 8, bit k for mailbox k). The flag stays set until the microcontroller writes 1 to that bit at address 8. Writing 0 to a bit leaves it unchanged.
- R7: `irq` is high exactly when the enable bit is 1 and at least one pending flag is set. With the enable at 0, `irq` stays low.
- R8: If the enable is written to 1 while a flag is already pending, `irq` rises at the same clock edge that stores the enable.
- R9: If a host write and a microcontroller clear of the same flag land on the same clock edge, the flag ends up set.
- R10: A host read leaves the pending flags unchanged. Holding `hst_req` high for many cycles causes only one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request level, asynchronous to clk |
| hst_dir | input | 1 | 1 = write inbound mailbox, 0 = read outbound mailbox |
| hst_idx | input | 2 | Host mailbox index |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Synchronized acknowledge |
| hst_rdata | output | 32 | Host read data |
| mcu_sel | input | 1 | Microcontroller access select |
| mcu_we | input | 1 | Microcontroller write enable |
| mcu_addr | input | 4 | Microcontroller register address |
| mcu_wdata | input | 32 | Microcontroller write data |
| mcu_rdata | output | 32 | Microcontroller read data (combinational) |
| irq | output | 1 | Interrupt to the microcontroller |

## Verification
Nearly all of the state can be seen at the ports. If the synchronizer or edge detector is wrong, `hst_ack` rises at the wrong edge, or a single held request causes two accesses. That second case shows up as a pending flag that comes back after being cleared while the request is still high. A wrong pending flag shows up as the wrong value at address 8, and as the wrong `irq` level, on the cycle right after the edge that changed it. A wrong precedence between set and clear is caught by a test that makes both land on the same edge and then reads address 8.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_DATA_W = 32;
    localparam int unsigned MBX_NUM    = 4;
    localparam int unsigned MBX_ADDR_W = 4;

    typedef enum logic [2:0] {
        RGN_INBOUND,
        RGN_OUTBOUND,
        RGN_PENDING,
        RGN_ENABLE,
        RGN_NONE
    } mcu_region_e;

    function automatic mcu_region_e region_of(input logic [MBX_ADDR_W-1:0] addr,
                                              input int unsigned num);
        int unsigned a;
        a = int'(addr);
        if (a < num)
            return RGN_INBOUND;
        else if (a < 2 * num)
            return RGN_OUTBOUND;
        else if (a == 2 * num)
            return RGN_PENDING;
        else if (a == 2 * num + 1)
            return RGN_ENABLE;
        return RGN_NONE;
    endfunction

endpackage

// File: rtl/mbx_host_sync.sv
module mbx_host_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic strobe,
    output logic ack
);
    logic [STAGES-1:0] sync_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], req_async};
            seen_q <= sync_q[STAGES-1];
        end
    end

    assign strobe = sync_q[STAGES-1] & ~seen_q;
    assign ack    = seen_q;
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM    = 4,
    localparam int unsigned IDX_W = $clog2(NUM)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_we,
    input  logic [IDX_W-1:0]      in_idx,
    input  logic [DATA_W-1:0]     in_wdata,
    input  logic                  out_we,
    input  logic [IDX_W-1:0]      out_idx,
    input  logic [DATA_W-1:0]     out_wdata,
    input  logic                  hrd_en,
    input  logic [IDX_W-1:0]      hrd_idx,
    input  logic [IDX_W-1:0]      mrd_idx,
    output logic [DATA_W-1:0]     in_rd,
    output logic [DATA_W-1:0]     out_rd,
    output logic [DATA_W-1:0]     hrd_data,
    output logic [NUM*DATA_W-1:0] in_flat
);
    logic [DATA_W-1:0] in_q  [NUM];
    logic [DATA_W-1:0] out_q [NUM];
    logic [DATA_W-1:0] hrd_q;

    for (genvar k = 0; k < NUM; k++) begin : g_box
        always_ff @(posedge clk) begin
            if (rst) begin
                in_q[k]  <= '0;
                out_q[k] <= '0;
            end else begin
                if (in_we && in_idx == IDX_W'(k))
                    in_q[k] <= in_wdata;
                if (out_we && out_idx == IDX_W'(k))
                    out_q[k] <= out_wdata;
            end
        end
        assign in_flat[k*DATA_W +: DATA_W] = in_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            hrd_q <= '0;
        else if (hrd_en)
            hrd_q <= out_q[hrd_idx];
    end

    assign in_rd    = in_q[mrd_idx];
    assign out_rd   = out_q[mrd_idx];
    assign hrd_data = hrd_q;
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
    parameter int unsigned NUM = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] set_vec,
    input  logic [NUM-1:0] clr_vec,
    input  logic           en_we,
    input  logic           en_val,
    output logic [NUM-1:0] pend,
    output logic           en,
    output logic           irq
);
    logic [NUM-1:0] pend_q;
    logic           en_q;

    for (genvar k = 0; k < NUM; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[k] <= 1'b0;
            else
                pend_q[k] <= set_vec[k] | (pend_q[k] & ~clr_vec[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (en_we)
            en_q <= en_val;
    end

    assign pend = pend_q;
    assign en   = en_q;
    assign irq  = en_q & (|pend_q);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = MBX_DATA_W,
    parameter int unsigned NUM         = MBX_NUM,
    parameter int unsigned ADDR_W      = MBX_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req,
    input  logic              hst_dir,
    input  logic [IDX_W-1:0]  hst_idx,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic              hst_ack,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              mcu_sel,
    input  logic              mcu_we,
    input  logic [ADDR_W-1:0] mcu_addr,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] mcu_rdata,
    output logic              irq
);
    logic              hst_strobe;
    logic              hst_wr;
    logic              hst_rd;
    mcu_region_e       rgn;
    logic              mcu_wr;
    logic [IDX_W-1:0]  mcu_idx;
    logic [NUM-1:0]    set_vec;
    logic [NUM-1:0]    clr_vec;
    logic [NUM-1:0]    pend;
    logic              en;
    logic [DATA_W-1:0] in_rd;
    logic [DATA_W-1:0] out_rd;
    logic [NUM*DATA_W-1:0] in_flat;

    mbx_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (hst_req),
        .strobe    (hst_strobe),
        .ack       (hst_ack)
    );

    assign hst_wr  = hst_strobe & hst_dir;
    assign hst_rd  = hst_strobe & ~hst_dir;
    assign rgn     = region_of(mcu_addr, NUM);
    assign mcu_wr  = mcu_sel & mcu_we;
    assign mcu_idx = mcu_addr[IDX_W-1:0];

    always_comb begin
        set_vec = '0;
        if (hst_wr)
            set_vec[hst_idx] = 1'b1;
    end

    assign clr_vec = (mcu_wr && rgn == RGN_PENDING) ? mcu_wdata[NUM-1:0] : '0;

    mbx_store #(.DATA_W(DATA_W), .NUM(NUM)) u_store (
        .clk       (clk),
        .rst       (rst),
        .in_we     (hst_wr),
        .in_idx    (hst_idx),
        .in_wdata  (hst_wdata),
        .out_we    (mcu_wr && rgn == RGN_OUTBOUND),
        .out_idx   (mcu_idx),
        .out_wdata (mcu_wdata),
        .hrd_en    (hst_rd),
        .hrd_idx   (hst_idx),
        .mrd_idx   (mcu_idx),
        .in_rd     (in_rd),
        .out_rd    (out_rd),
        .hrd_data  (hst_rdata),
        .in_flat   (in_flat)
    );

    mbx_status #(.NUM(NUM)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_we   (mcu_wr && rgn == RGN_ENABLE),
        .en_val  (mcu_wdata[0]),
        .pend    (pend),
        .en      (en),
        .irq     (irq)
    );

    always_comb begin
        mcu_rdata = '0;
        if (mcu_sel) begin
            unique case (rgn)
                RGN_INBOUND:  mcu_rdata = in_rd;
                RGN_OUTBOUND: mcu_rdata = out_rd;
                RGN_PENDING:  mcu_rdata = DATA_W'(pend);
                RGN_ENABLE:   mcu_rdata = DATA_W'(en);
                default:      mcu_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM    = 4,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hst_req,
    input logic              hst_ack,
    input logic              hst_strobe,
    input logic              irq,
    input logic              en,
    input logic [NUM-1:0]    pend,
    input logic [NUM-1:0]    set_vec,
    input logic              mcu_sel,
    input logic              mcu_we,
    input logic [ADDR_W-1:0] mcu_addr,
    input logic [NUM*DATA_W-1:0] in_flat
);
    logic pend_wr;
    logic in_wr;
    assign pend_wr = mcu_sel && mcu_we && (int'(mcu_addr) == 2 * NUM);
    assign in_wr   = mcu_sel && mcu_we && (int'(mcu_addr) < NUM);

    a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
        $rose(hst_ack) |-> $past(hst_req, 3));

    a_r5_inbound_readonly: assert property (@(posedge clk) disable iff (rst)
        (in_wr && !hst_strobe) |=> $stable(in_flat));

    a_r6_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        !pend_wr |=> ((pend & $past(pend)) == $past(pend)));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
        hst_strobe |=> !hst_strobe);
endmodule

bind mbx_bank mbx_bank_chk #(.DATA_W(DATA_W), .NUM(NUM), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hst_req    (hst_req),
    .hst_ack    (hst_ack),
    .hst_strobe (hst_strobe),
    .irq        (irq),
    .en         (en),
    .pend       (pend),
    .set_vec    (set_vec),
    .mcu_sel    (mcu_sel),
    .mcu_we     (mcu_we),
    .mcu_addr   (mcu_addr),
    .in_flat    (in_flat)
);

// File: tb/sim_mbx_bank.sv
module sim_mbx_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0;
    logic        hst_dir = 1'b0;
    logic [1:0]  hst_idx = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ack;
    logic [31:0] hst_rdata;
    logic        mcu_sel = 1'b0;
    logic        mcu_we = 1'b0;
    logic [3:0]  mcu_addr = '0;
    logic [31:0] mcu_wdata = '0;
    logic [31:0] mcu_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mbx_bank u0 (.*);

    // kind: 0 host write, 1 host read (check), 2 mcu write, 3 mcu read (check)
    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  where;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 4'd4, 32'h0000_00A1, 4'd4},  // R4 outbound 0
        '{2'd2, 4'd7, 32'h0000_00B7, 4'd4},  // R4 outbound 3
        '{2'd1, 4'd0, 32'h0000_00A1, 4'd3},  // R3
        '{2'd1, 4'd3, 32'h0000_00B7, 4'd3},  // R3
        '{2'd0, 4'd1, 32'h0000_00C1, 4'd2},  // R2
        '{2'd3, 4'd1, 32'h0000_00C1, 4'd2},  // R2
        '{2'd3, 4'd8, 32'h0000_0002, 4'd6},  // R6
        '{2'd2, 4'd1, 32'h0000_00FF, 4'd5},  // R5 ignored
        '{2'd3, 4'd1, 32'h0000_00C1, 4'd5},  // R5
        '{2'd0, 4'd2, 32'h0000_00D2, 4'd2},  // R2
        '{2'd3, 4'd8, 32'h0000_0006, 4'd6},  // R6
        '{2'd2, 4'd8, 32'h0000_0002, 4'd6},  // R6 clear bit 1
        '{2'd3, 4'd8, 32'h0000_0004, 4'd6},  // R6
        '{2'd3, 4'd7, 32'h0000_00B7, 4'd4}   // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mcu_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        mcu_sel = 1'b1; mcu_we = 1'b1; mcu_addr = a; mcu_wdata = d;
        @(negedge clk);
        mcu_sel = 1'b0; mcu_we = 1'b0;
    endtask

    task automatic mcu_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        mcu_sel = 1'b1; mcu_we = 1'b0; mcu_addr = a;
        #1 d = mcu_rdata;
        mcu_sel = 1'b0;
    endtask

    // returns edges from request to acknowledge
    task automatic hst_xfer(input logic dir, input logic [1:0] idx,
                            input logic [31:0] d, output int edges);
        @(negedge clk);
        hst_dir = dir; hst_idx = idx; hst_wdata = d; hst_req = 1'b1;
        edges = 0;
        while (!hst_ack && edges < 20) begin
            @(negedge clk);
            edges++;
        end
        hst_req = 1'b0;
        while (hst_ack) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        int e;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", {31'b0, hst_ack}, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        mcu_rd(4'd8, rd); check("R1 pending", rd, 32'd0);
        mcu_rd(4'd9, rd); check("R1 enable", rd, 32'd0);
        mcu_rd(4'd2, rd); check("R1 inbound", rd, 32'd0);
        mcu_rd(4'd6, rd); check("R1 outbound", rd, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 acknowledge latency
        hst_xfer(1'b1, 2'd0, 32'h1234_5678, e);
        check("R2 ack latency", e, 32'd3);
        mcu_rd(4'd0, rd); check("R2 inbound 0", rd, 32'h1234_5678);
        mcu_wr(4'd8, 32'h1);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].kind)
                2'd0: hst_xfer(1'b1, VECS[i].where[1:0], VECS[i].data, e);
                2'd1: begin
                    hst_xfer(1'b0, VECS[i].where[1:0], 32'h0, e);
                    check(tg, hst_rdata, VECS[i].data);
                end
                2'd2: mcu_wr(VECS[i].where, VECS[i].data);
                default: begin
                    mcu_rd(VECS[i].where, rd);
                    check(tg, rd, VECS[i].data);
                end
            endcase
        end

        // R7 pending flag 2 set, enable off
        @(negedge clk);
        check("R7 irq masked", {31'b0, irq}, 32'd0);
        // R8 enable while pending: irq right after the storing edge
        @(negedge clk);
        mcu_sel = 1'b1; mcu_we = 1'b1; mcu_addr = 4'd9; mcu_wdata = 32'h1;
        @(negedge clk);
        mcu_sel = 1'b0; mcu_we = 1'b0;
        check("R8 irq immediate", {31'b0, irq}, 32'd1);
        mcu_wr(4'd8, 32'h4);
        check("R7 irq cleared", {31'b0, irq}, 32'd0);

        // R10 host read leaves flags alone
        hst_xfer(1'b0, 2'd1, 32'h0, e);
        mcu_rd(4'd8, rd); check("R10 read no flag", rd, 32'd0);
        check("R10 read irq", {31'b0, irq}, 32'd0);

        // R9 same-edge set and clear of flag 3
        hst_xfer(1'b1, 2'd3, 32'h3333_0000, e);
        @(negedge clk);
        hst_dir = 1'b1; hst_idx = 2'd3; hst_wdata = 32'h3333_1111; hst_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mcu_sel = 1'b1; mcu_we = 1'b1; mcu_addr = 4'd8; mcu_wdata = 32'h8;
        @(negedge clk);
        mcu_sel = 1'b0; mcu_we = 1'b0;
        mcu_rd(4'd8, rd); check("R9 set wins", rd, 32'h8);
        check("R9 irq", {31'b0, irq}, 32'd1);
        mcu_rd(4'd3, rd); check("R9 data", rd, 32'h3333_1111);

        // R10 held request: clear flag while still requesting, must stay clear
        mcu_wr(4'd8, 32'h8);
        repeat (10) @(negedge clk);
        mcu_rd(4'd8, rd); check("R10 held single", rd, 32'd0);
        check("R10 held ack", {31'b0, hst_ack}, 32'd1);
        hst_req = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 ack drops", {31'b0, hst_ack}, 32'd0);

        // R6 writing zero keeps a flag
        hst_xfer(1'b1, 2'd2, 32'h5, e);
        mcu_wr(4'd8, 32'h0);
        mcu_rd(4'd8, rd); check("R6 zero keeps", rd, 32'h4);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule